// File: doc/BRIEF.md
# RC4 Keystream Cipher Core

This core encrypts or decrypts a byte stream with the RC4 stream cipher. Software or a host block first writes the secret key, one byte at a time, into a small key bank. It selects a key length of 1 to 16 bytes and pulses `start_i`. The core then resets its 256-entry permutation to the identity and runs the key-scheduling pass. That pass takes 256 iterations of three cycles each.

Once scheduling finishes, the core raises `in_ready_o`. Each byte accepted on the data input is combined with the next keystream byte, and the result comes out on `out_data_o` with a one-cycle `out_valid_o` strobe. The same operation both encrypts and decrypts, because the result is the XOR of the data and the keystream. Every keystream byte costs exactly three cycles. A key of any length therefore needs 768 cycles of scheduling plus 3 cycles per byte.

Top module: `rc4_core`

## Requirements
- R1: While `rst_n` is low and right after it is released, `busy_o`, `in_ready_o` and `out_valid_o` are all low.
- R2: A `start_i` pulse seen while the core is idle or waiting for data is accepted. It latches the key length (`key_len_m1_i` + 1 bytes) and reloads the identity permutation at that same clock edge, and `busy_o` is high in the next cycle.
- R3: After an accepted start, `busy_o` stays high for exactly 768 cycles, and `in_ready_o` is high in the cycle that follows.
- R4: Key scheduling runs index i from 0 to 255. In each step, j becomes j + S[i] + K[i mod L] (mod 256) and then S[i] and S[j] are swapped, where K[p] is the byte written at key address p and L is the latched length.
- R5: Generation starts with i = j = 0. For each accepted byte: i becomes i+1, j becomes j+S[i], S[i] and S[j] are swapped, and the keystream byte is S[(S[i]+S[j]) mod 256].
- R6: A byte accepted at clock edge E (`in_valid_i` and `in_ready_o` both high) produces `out_valid_o` high for one cycle after edge E+2. At that point `out_data_o` equals the input byte XOR the keystream byte.
- R7: After each accepted byte, `in_ready_o` is low for exactly two cycles and then high again, so a continuous stream runs at one byte per three cycles.
- R8: When the keystream index t equals i or j, the keystream byte is the value just written by the swap in that cycle.
- R9: A `start_i` pulse while `busy_o` is high has no effect: scheduling and the keystream continue as if it never came.
- R10: Key bank writes (`key_wr_i`, address 0 to 15) while `busy_o` is high are ignored.
- R11: If `start_i` is high while the core waits for data, `in_ready_o` is low in that cycle and the data byte is not consumed.
- R12: `in_ready_o` is never high while `busy_o` is high, and it stays low until a key has been scheduled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_wr_i | input | 1 | Write strobe for one key byte |
| key_addr_i | input | 4 | Key byte position (0 to 15) |
| key_data_i | input | 8 | Key byte value |
| key_len_m1_i | input | 4 | Key length minus one, latched at start |
| start_i | input | 1 | Begin key scheduling with the current key |
| in_valid_i | input | 1 | Data byte present |
| in_data_i | input | 8 | Plaintext or ciphertext byte |
| in_ready_o | output | 1 | Core can take a data byte |
| out_valid_o | output | 1 | Result byte strobe |
| out_data_o | output | 8 | Data XOR keystream |
| busy_o | output | 1 | Scheduling or a byte in flight |

## Verification
Five properties are checked on every cycle. `busy_o` and `in_ready_o` never overlap. Busy stays high for the whole 768-cycle scheduling window and drops exactly at its end. Every accepted byte yields a result strobe three edges later. Every acceptance is followed by two not-ready cycles. The values of the keystream can only be shown by the bench scenarios, which compare each result with a behavioural cipher model and with published vectors, across key lengths 1, 3, 4, 5 and 16. The same holds for the ignored starts and key writes during scheduling, the start-over-data priority, and the forwarding case t = i or t = j, which a long stream is relied on to reach.

// File: rtl/rc4_pkg.sv
// Shared constants and types for the RC4 keystream core.
// Assumes the cipher's fixed 8-bit word and 256-entry permutation.
package rc4_pkg;
    localparam int BYTE_W     = 8;
    localparam int SBOX_DEPTH = 256;
    localparam int SBOX_AW    = $clog2(SBOX_DEPTH);
    localparam int KSA_CYCLES = SBOX_DEPTH * 3;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KSA_RD_I,
        ST_KSA_RD_J,
        ST_KSA_SWAP,
        ST_GEN_WAIT,
        ST_GEN_RD_J,
        ST_GEN_SWAP
    } seq_state_e;
endpackage

// File: rtl/rc4_key_bank.sv
// Key byte store: KEY_MAX byte registers, written one byte at a time.
// Assumes writes are locked out (lock_i) while the sequencer uses the key.
module rc4_key_bank #(
    parameter int KEY_MAX = 16,
    localparam int KIDX_W = $clog2(KEY_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lock_i,
    input  logic              wr_i,
    input  logic [KIDX_W-1:0] wr_addr_i,
    input  logic [7:0]        wr_data_i,
    input  logic [KIDX_W-1:0] rd_idx_i,
    output logic [7:0]        rd_data_o
);
    logic [7:0] key_q [KEY_MAX];

    // Capture host key writes unless the key is in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < KEY_MAX; k++) key_q[k] <= '0;
        end else if (wr_i && !lock_i && (int'(wr_addr_i) < KEY_MAX)) begin
            key_q[wr_addr_i] <= wr_data_i;
        end
    end

    // Present the key byte selected by the sequencer.
    always_comb begin
        rd_data_o = key_q[rd_idx_i];
    end
endmodule

// File: rtl/rc4_state_mem.sv
// Permutation store: DEPTH byte cells with three asynchronous read ports and
// two write ports used together for the swap. init_i reloads the identity
// permutation in a single cycle. Assumes DEPTH <= 2**W. When both write
// addresses match, port B wins (the swap then writes equal values).
module rc4_state_mem #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          we_i,
    input  logic [AW-1:0] wa_a_i,
    input  logic [W-1:0]  wd_a_i,
    input  logic [AW-1:0] wa_b_i,
    input  logic [W-1:0]  wd_b_i,
    input  logic [AW-1:0] ra_a_i,
    output logic [W-1:0]  rd_a_o,
    input  logic [AW-1:0] ra_b_i,
    output logic [W-1:0]  rd_b_o,
    input  logic [AW-1:0] ra_c_i,
    output logic [W-1:0]  rd_c_o
);
    logic [DEPTH*W-1:0] flat;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [W-1:0] cell_q;

        // Hold one permutation entry; identity on reset or init.
        always_ff @(posedge clk) begin
            if (!rst_n || init_i) begin
                cell_q <= W'(g);
            end else if (we_i && (wa_b_i == AW'(g))) begin
                cell_q <= wd_b_i;
            end else if (we_i && (wa_a_i == AW'(g))) begin
                cell_q <= wd_a_i;
            end
        end

        assign flat[g*W +: W] = cell_q;
    end

    // Three independent read multiplexers.
    always_comb begin
        rd_a_o = flat[ra_a_i*W +: W];
        rd_b_o = flat[ra_b_i*W +: W];
        rd_c_o = flat[ra_c_i*W +: W];
    end
endmodule

// File: rtl/rc4_sequencer.sv
// Control and datapath for key scheduling and keystream generation.
// Each scheduling step and each keystream byte uses three states:
// read S[i], read S[j], then swap (and for keystream, read S[t]).
// Assumes asynchronous reads from the permutation store.
module rc4_sequencer
    import rc4_pkg::*;
#(
    parameter int KEY_MAX = 16,
    localparam int KIDX_W = $clog2(KEY_MAX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [KIDX_W-1:0]  key_len_m1_i,
    input  logic               in_valid_i,
    input  byte_t              in_data_i,
    output logic               in_ready_o,
    output logic               busy_o,
    output logic               out_valid_o,
    output byte_t              out_data_o,
    output logic [KIDX_W-1:0]  key_idx_o,
    input  byte_t              key_byte_i,
    output logic               mem_init_o,
    output logic               mem_we_o,
    output logic [SBOX_AW-1:0] mem_wa_a_o,
    output byte_t              mem_wd_a_o,
    output logic [SBOX_AW-1:0] mem_wa_b_o,
    output byte_t              mem_wd_b_o,
    output logic [SBOX_AW-1:0] mem_ra_a_o,
    input  byte_t              mem_rd_a_i,
    output logic [SBOX_AW-1:0] mem_ra_b_o,
    input  byte_t              mem_rd_b_i,
    output logic [SBOX_AW-1:0] mem_ra_c_o,
    input  byte_t              mem_rd_c_i
);
    seq_state_e         state_q;
    logic [SBOX_AW-1:0] i_q, j_q, t_q;
    byte_t              si_q, sj_q, din_q;
    logic [KIDX_W-1:0]  kidx_q, klen_q;

    logic               start_ok, accept;
    logic [SBOX_AW-1:0] i_nxt;
    byte_t              ks_byte;

    // Handshake and status decode.
    always_comb begin
        start_ok   = start_i && ((state_q == ST_IDLE) || (state_q == ST_GEN_WAIT));
        busy_o     = !((state_q == ST_IDLE) || (state_q == ST_GEN_WAIT));
        in_ready_o = (state_q == ST_GEN_WAIT) && !start_i;
        accept     = in_valid_i && in_ready_o;
        i_nxt      = i_q + 1'b1;
    end

    // Memory addressing and swap write control.
    always_comb begin
        mem_init_o = start_ok;
        mem_we_o   = (state_q == ST_KSA_SWAP) || (state_q == ST_GEN_SWAP);
        mem_wa_a_o = j_q;
        mem_wd_a_o = si_q;
        mem_wa_b_o = i_q;
        mem_wd_b_o = sj_q;
        mem_ra_a_o = (state_q == ST_GEN_WAIT) ? i_nxt : i_q;
        mem_ra_b_o = j_q;
        mem_ra_c_o = t_q;
        key_idx_o  = kidx_q;
    end

    // Keystream byte with forwarding of the same-cycle swap writes.
    always_comb begin
        if (t_q == i_q) begin
            ks_byte = sj_q;
        end else if (t_q == j_q) begin
            ks_byte = si_q;
        end else begin
            ks_byte = mem_rd_c_i;
        end
    end

    // State machine, indices and holding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            i_q         <= '0;
            j_q         <= '0;
            t_q         <= '0;
            si_q        <= '0;
            sj_q        <= '0;
            din_q       <= '0;
            kidx_q      <= '0;
            klen_q      <= '0;
            out_valid_o <= 1'b0;
            out_data_o  <= '0;
        end else begin
            out_valid_o <= 1'b0;
            if (start_ok) begin
                state_q <= ST_KSA_RD_I;
                i_q     <= '0;
                j_q     <= '0;
                kidx_q  <= '0;
                klen_q  <= key_len_m1_i;
            end else begin
                unique case (state_q)
                    ST_KSA_RD_I: begin
                        si_q    <= mem_rd_a_i;
                        j_q     <= j_q + mem_rd_a_i + key_byte_i;
                        state_q <= ST_KSA_RD_J;
                    end
                    ST_KSA_RD_J: begin
                        sj_q    <= mem_rd_b_i;
                        state_q <= ST_KSA_SWAP;
                    end
                    ST_KSA_SWAP: begin
                        if (i_q == '1) begin
                            i_q     <= '0;
                            j_q     <= '0;
                            state_q <= ST_GEN_WAIT;
                        end else begin
                            i_q     <= i_nxt;
                            kidx_q  <= (kidx_q == klen_q) ? '0 : kidx_q + 1'b1;
                            state_q <= ST_KSA_RD_I;
                        end
                    end
                    ST_GEN_WAIT: begin
                        if (accept) begin
                            i_q     <= i_nxt;
                            si_q    <= mem_rd_a_i;
                            j_q     <= j_q + mem_rd_a_i;
                            din_q   <= in_data_i;
                            state_q <= ST_GEN_RD_J;
                        end
                    end
                    ST_GEN_RD_J: begin
                        sj_q    <= mem_rd_b_i;
                        t_q     <= si_q + mem_rd_b_i;
                        state_q <= ST_GEN_SWAP;
                    end
                    ST_GEN_SWAP: begin
                        out_valid_o <= 1'b1;
                        out_data_o  <= ks_byte ^ din_q;
                        state_q     <= ST_GEN_WAIT;
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/rc4_core.sv
// RC4 cipher core top: key bank, permutation store and sequencer.
// Assumes a key is written and started before data is offered.
module rc4_core
    import rc4_pkg::*;
#(
    parameter int KEY_MAX = 16,
    localparam int KIDX_W = $clog2(KEY_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr_i,
    input  logic [KIDX_W-1:0] key_addr_i,
    input  logic [7:0]        key_data_i,
    input  logic [KIDX_W-1:0] key_len_m1_i,
    input  logic              start_i,
    input  logic              in_valid_i,
    input  logic [7:0]        in_data_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic [7:0]        out_data_o,
    output logic              busy_o
);
    logic [KIDX_W-1:0]  key_idx;
    byte_t              key_byte;
    logic               mem_init, mem_we;
    logic [SBOX_AW-1:0] wa_a, wa_b, ra_a, ra_b, ra_c;
    byte_t              wd_a, wd_b, rd_a, rd_b, rd_c;

    rc4_key_bank #(.KEY_MAX(KEY_MAX)) u_keys (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_i    (busy_o),
        .wr_i      (key_wr_i),
        .wr_addr_i (key_addr_i),
        .wr_data_i (key_data_i),
        .rd_idx_i  (key_idx),
        .rd_data_o (key_byte)
    );

    rc4_state_mem #(.DEPTH(SBOX_DEPTH), .W(BYTE_W)) u_sbox (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (mem_init),
        .we_i   (mem_we),
        .wa_a_i (wa_a),
        .wd_a_i (wd_a),
        .wa_b_i (wa_b),
        .wd_b_i (wd_b),
        .ra_a_i (ra_a),
        .rd_a_o (rd_a),
        .ra_b_i (ra_b),
        .rd_b_o (rd_b),
        .ra_c_i (ra_c),
        .rd_c_o (rd_c)
    );

    rc4_sequencer #(.KEY_MAX(KEY_MAX)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .key_len_m1_i (key_len_m1_i),
        .in_valid_i   (in_valid_i),
        .in_data_i    (in_data_i),
        .in_ready_o   (in_ready_o),
        .busy_o       (busy_o),
        .out_valid_o  (out_valid_o),
        .out_data_o   (out_data_o),
        .key_idx_o    (key_idx),
        .key_byte_i   (key_byte),
        .mem_init_o   (mem_init),
        .mem_we_o     (mem_we),
        .mem_wa_a_o   (wa_a),
        .mem_wd_a_o   (wd_a),
        .mem_wa_b_o   (wa_b),
        .mem_wd_b_o   (wd_b),
        .mem_ra_a_o   (ra_a),
        .mem_rd_a_i   (rd_a),
        .mem_ra_b_o   (ra_b),
        .mem_rd_b_i   (rd_b),
        .mem_ra_c_o   (ra_c),
        .mem_rd_c_i   (rd_c)
    );
endmodule

// File: rtl/rc4_core_chk.sv
// Protocol checker for rc4_core, attached with bind. Tracks the scheduling
// window with a counter instead of a long delay.
module rc4_core_chk #(
    parameter int KSA_CYC = 768,
    localparam int CW     = $clog2(KSA_CYC + 2) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic in_valid_i,
    input logic in_ready_o,
    input logic out_valid_o
);
    logic          win_q;
    logic [CW-1:0] cnt_q;

    // Count cycles since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            cnt_q <= '0;
        end else if (start_i && !busy_o) begin
            win_q <= 1'b1;
            cnt_q <= CW'(1);
        end else if (win_q) begin
            if (cnt_q == CW'(KSA_CYC + 1)) win_q <= 1'b0;
            else cnt_q <= cnt_q + 1'b1;
        end
    end

    // R12
    busy_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && in_ready_o));

    // R3
    ksa_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q && cnt_q <= CW'(KSA_CYC)) |-> busy_o);

    // R3
    ksa_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q && cnt_q == CW'(KSA_CYC + 1)) |-> (!busy_o && (in_ready_o || start_i)));

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R6
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |-> ##3 out_valid_o);

    // R7
    ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> !in_ready_o ##1 !in_ready_o);
endmodule

bind rc4_core rc4_core_chk #(.KSA_CYC(rc4_pkg::KSA_CYCLES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o)
);

// File: tb/rc4_core_tb.sv
module rc4_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       key_wr = 1'b0;
    logic [3:0] key_addr = '0;
    logic [7:0] key_data = '0;
    logic [3:0] key_len_m1 = '0;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, out_valid, busy;
    logic [7:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #5 clk = ~clk;

    rc4_core u_dut (
        .clk(clk), .rst_n(rst_n), .key_wr_i(key_wr), .key_addr_i(key_addr),
        .key_data_i(key_data), .key_len_m1_i(key_len_m1), .start_i(start),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
        .out_valid_o(out_valid), .out_data_o(out_data), .busy_o(busy)
    );

    // Behavioural cipher model, updated from what is seen at the ports.
    int         ms [256];
    int         mi, mj, mlen;
    int         mkey [16];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];
    logic       p0 = 0, p1 = 0, p2 = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            p0 = 0; p1 = 0; p2 = 0;
        end else begin
            if (p2 || out_valid) begin
                if (out_valid !== p2) begin
                    chk(0, "R6 out_valid timing", int'(out_valid), int'(p2));
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    got_q.push_back(out_data);
                    chk(out_data === e, "R5/R6 result byte", int'(out_data), int'(e));
                end
            end
            p2 = p1; p1 = p0;
            p0 = in_valid && in_ready;
            if (key_wr && !busy) mkey[key_addr] = int'(key_data);
            if (start && !busy) begin
                int tmp;
                mlen = int'(key_len_m1) + 1;
                for (int k = 0; k < 256; k++) ms[k] = k;
                mj = 0;
                for (int k = 0; k < 256; k++) begin
                    mj = (mj + ms[k] + mkey[k % mlen]) % 256;
                    tmp = ms[k]; ms[k] = ms[mj]; ms[mj] = tmp;
                end
                mi = 0; mj = 0;
            end
            if (p0) begin
                int tmp;
                mi = (mi + 1) % 256;
                mj = (mj + ms[mi]) % 256;
                tmp = ms[mi]; ms[mi] = ms[mj]; ms[mj] = tmp;
                exp_q.push_back(in_data ^ 8'(ms[(ms[mi] + ms[mj]) % 256]));
            end
        end
    end

    // Watchdog: a hung run is a failure but still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_key(input logic [7:0] kb [16], input int len);
        for (int k = 0; k < len; k++) begin
            key_wr = 1; key_addr = 4'(k); key_data = kb[k];
            tick();
        end
        key_wr = 0;
    endtask

    // Start scheduling; optionally inject a start and key write at step inj.
    task automatic start_key(input int len, input int inj);
        int n;
        key_len_m1 = 4'(len - 1);
        start = 1;
        tick();
        start = 0;
        chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        n = 0;
        while (!in_ready && n < 2000) begin
            if (n == inj) begin
                start = 1; key_len_m1 = 4'd0;
                key_wr = 1; key_addr = 4'd0; key_data = 8'hFF;
            end
            tick();
            start = 0; key_wr = 0;
            n++;
        end
        chk(n == 768, "R3 schedule length", n, 768);
    endtask

    task automatic send(input logic [7:0] b);
        int n;
        n = 0;
        while (!in_ready && n < 2000) begin tick(); n++; end
        in_valid = 1; in_data = b;
        tick();
        in_valid = 0;
        n = 0;
        while (!in_ready && n < 10) begin tick(); n++; end
        chk(n == 2, "R7 ready gap", n, 2);
    endtask

    task automatic drain();
        repeat (5) tick();
    endtask

    initial begin
        logic [7:0] kb [16];
        logic [7:0] kv [9];

        // R1: reset state
        repeat (3) tick();
        chk(!busy && !in_ready && !out_valid, "R1 in reset", {busy, in_ready, out_valid}, 0);
        rst_n = 1;
        tick();
        chk(!busy && !in_ready && !out_valid, "R1 after reset", {busy, in_ready, out_valid}, 0);

        // R12: no data taken before any key is scheduled
        in_valid = 1; in_data = 8'h33;
        repeat (4) begin
            tick();
            chk(in_ready === 1'b0, "R12 not ready before key", int'(in_ready), 0);
        end
        in_valid = 0;
        drain();
        chk(out_valid === 1'b0, "R12 no output before key", int'(out_valid), 0);

        // R4 R5: published vector, 3-byte key
        kb = '{default: 8'h00};
        kb[0] = 8'h4B; kb[1] = 8'h65; kb[2] = 8'h79;
        load_key(kb, 3);
        start_key(3, -1);
        got_q.delete();
        kv = '{8'h50, 8'h6C, 8'h61, 8'h69, 8'h6E, 8'h74, 8'h65, 8'h78, 8'h74};
        for (int k = 0; k < 9; k++) send(kv[k]);
        drain();
        kv = '{8'hBB, 8'hF3, 8'h16, 8'hE8, 8'hD9, 8'h40, 8'hAF, 8'h0A, 8'hD3};
        chk(got_q.size() == 9, "R5 vector count", got_q.size(), 9);
        for (int k = 0; k < 9 && k < got_q.size(); k++)
            chk(got_q[k] === kv[k], "R4 R5 known vector Key", int'(got_q[k]), int'(kv[k]));

        // 1-byte key with gaps between bytes
        kb[0] = 8'hA5;
        load_key(kb, 1);
        start_key(1, -1);
        for (int k = 0; k < 40; k++) begin
            send(8'(k * 7));
            repeat (k % 3) tick();
        end
        drain();

        // R9 R10: 16-byte key, start and key write injected mid-schedule
        for (int k = 0; k < 16; k++) kb[k] = 8'(k * 17 + 3);
        load_key(kb, 16);
        start_key(16, 100);
        // long back-to-back stream, reaching t==i / t==j cases (R8)
        for (int k = 0; k < 600; k++) send(8'(k ^ 8'h5A));
        drain();
        chk(exp_q.size() == 0, "R8 R9 R10 stream complete", exp_q.size(), 0);

        // R11: start and data together while waiting for data
        kb[0] = 8'h01; kb[1] = 8'h23; kb[2] = 8'h45; kb[3] = 8'h67; kb[4] = 8'h89;
        load_key(kb, 5);
        key_len_m1 = 4'd4;
        start = 1; in_valid = 1; in_data = 8'hEE;
        #1;
        chk(in_ready === 1'b0, "R11 ready low on start", int'(in_ready), 0);
        tick();
        start = 0; in_valid = 0;
        chk(busy === 1'b1, "R2 R11 restart accepted", int'(busy), 1);
        begin
            int n;
            n = 0;
            while (!in_ready && n < 2000) begin tick(); n++; end
            chk(n == 768, "R3 restart schedule length", n, 768);
        end
        for (int k = 0; k < 50; k++) send(8'(255 - k));
        drain();

        // R4 R5: second published vector, 4-byte key
        kb[0] = 8'h57; kb[1] = 8'h69; kb[2] = 8'h6B; kb[3] = 8'h69;
        load_key(kb, 4);
        start_key(4, -1);
        got_q.delete();
        kv = '{8'h70, 8'h65, 8'h64, 8'h69, 8'h61, 8'h00, 8'h00, 8'h00, 8'h00};
        for (int k = 0; k < 5; k++) send(kv[k]);
        drain();
        kv = '{8'h10, 8'h21, 8'hBF, 8'h04, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00};
        for (int k = 0; k < 5 && k < got_q.size(); k++)
            chk(got_q[k] === kv[k], "R4 R5 known vector Wiki", int'(got_q[k]), int'(kv[k]));
        chk(exp_q.size() == 0, "R6 all results seen", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule